// File: doc/BRIEF.md
# UART Register Front End

This block is the software-visible register layer of a serial port. It sits on a simple single-cycle read/write bus. A transmit queue and a receive queue sit behind one data register. A flag register reports whether the receive queue is empty and whether the transmit queue is full. Further registers hold the integer and fractional parts of the baud divisor, the line settings and a port-enable bit.

Software first clears the enable bit. It then programs the divisor and line settings, sets the enable bit again, and moves bytes by polling the flags. The divisor words and the word-length field are driven out to the serial bit engines. Bytes leave the transmit queue through a byte/valid/ready handshake. Bytes enter the receive queue from a valid-qualified byte input.

When the queues are turned off in the line settings, each queue holds a single byte. The flags then report full or empty for a depth of one.

Top module: `uart_reg_front`

## Requirements
- R1: After reset, every register reads zero except the flag register, which reads 0x10 (receive-empty set, transmit-full clear). Both queues are empty, `tx_valid` is low, and `baud_int`, `baud_frac` and `word_len` are zero.
- R2: A bus write to offset 0x000 pushes bits 7:0 into the transmit queue. While enabled and the queue is not empty, `tx_valid` is high and `tx_data` shows the oldest byte. Each cycle with `tx_valid` and `tx_ready` both high removes one byte, in first-in first-out order.
- R3: With the queues enabled (line-control bit 4 = 1), flag bit 5 reads 1 once DEPTH bytes are queued for transmit. A data write made while the queue is full is dropped.
- R4: Flag register offset 0x018 bit 4 reads 1 while the receive queue is empty and 0 once it holds a byte. Reads of offset 0x000 return received bytes in bits 7:0, in arrival order, each read removing one.
- R5: A read of offset 0x000 while the receive queue is empty returns zero and leaves the queue unchanged.
- R6: With line-control bit 4 = 0, each queue holds one byte. Flag bit 5 reads 1 after one queued transmit byte, and further data writes and received bytes are dropped while the one slot is occupied.
- R7: While control offset 0x030 bit 0 is 0, `tx_valid` stays low and incoming receive bytes are discarded. Bytes already queued for transmit are kept and offered once the bit is set.
- R8: The integer divisor at offset 0x024 keeps bits 15:0 and the fractional divisor at offset 0x028 keeps bits 5:0. They read back masked to those widths and drive `baud_int` and `baud_frac`.
- R9: Line control at offset 0x02C keeps bits 6:4 and reads back only those bits. Bits 6:5 drive `word_len` (2'b11 = 8 data bits) and bit 4 is the queue enable. Control keeps only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit byte offered to the serializer |
| tx_ready | input | 1 | Serializer accepts the offered byte |
| rx_data | input | 8 | Byte from the deserializer |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| baud_int | output | 16 | Integer baud divisor |
| baud_frac | output | 6 | Fractional baud divisor |
| word_len | output | 2 | Word-length select |

## Verification
The assertions assume that each bus access lasts one cycle with a stable address and write flag. They also assume that the serializer holds `tx_ready` as a plain level, which the handshake check relies on, and that `rx_valid` marks single-cycle byte arrivals. The bench changes every input only on the falling clock edge and raises `bus_sel` for exactly one cycle per access. It pulses `rx_valid` for one cycle per byte and holds `tx_ready` low except when it deliberately drains the transmit queue, so every stimulus stays inside those assumptions.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int IBRD_W = 16;
    localparam int FBRD_W = 6;

    // word offsets seen by software
    localparam logic [ADDR_W-1:0] OFS_DATA = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_IDIV = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_FDIV = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_LINE = 12'h02C;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h030;

    // bit positions
    localparam int FLG_RX_EMPTY = 4;
    localparam int FLG_TX_FULL  = 5;
    localparam int LN_QUEUE_EN  = 4;
    localparam int LN_WLEN_LO   = 5;
    localparam int CT_PORT_EN   = 0;

    typedef struct packed {
        logic [IBRD_W-1:0] idiv;
        logic [FBRD_W-1:0] fdiv;
        logic [1:0]        wlen;
        logic              q_en;
        logic              port_en;
    } cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_FLAG,
        SEL_IDIV,
        SEL_FDIV,
        SEL_LINE,
        SEL_CTRL
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] w;
        w = {a[ADDR_W-1:2], 2'b00};
        case (w)
            OFS_DATA: return SEL_DATA;
            OFS_FLAG: return SEL_FLAG;
            OFS_IDIV: return SEL_IDIV;
            OFS_FDIV: return SEL_FDIV;
            OFS_LINE: return SEL_LINE;
            OFS_CTRL: return SEL_CTRL;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_flags(input logic rx_empty,
                                                     input logic tx_full);
        logic [DATA_W-1:0] f;
        f = '0;
        f[FLG_RX_EMPTY] = rx_empty;
        f[FLG_TX_FULL]  = tx_full;
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] pack_line(input cfg_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[LN_WLEN_LO +: 2] = c.wlen;
        v[LN_QUEUE_EN]     = c.q_en;
        return v;
    endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         one_entry,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = one_entry ? (count != '0) : (count == CAP);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // R3: occupancy never exceeds the storage
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);

    // R3: a push into a full queue leaves the occupancy alone
    a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop |=> count == $past(count));

    // R5: popping an empty queue changes nothing
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
        empty && pop && !push |=> count == '0);

    // R6: in single-slot mode a push into an empty queue yields exactly one entry
    a_r6_one_slot: assert property (@(posedge clk) disable iff (rst)
        one_entry && empty && push |=> count == 1);

endmodule

// File: rtl/uart_bus_regs.sv
module uart_bus_regs
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_empty,
    input  logic              tx_full,
    input  logic [BYTE_W-1:0] rx_head,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_push_data,
    output logic              rx_pop,
    output cfg_t              cfg
);
    reg_sel_e sel;
    logic     wr_hit, rd_hit;
    logic     unused_bits;

    assign sel    = decode_addr(bus_addr);
    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;

    assign tx_push      = wr_hit && (sel == SEL_DATA);
    assign tx_push_data = bus_wdata[BYTE_W-1:0];
    assign rx_pop       = rd_hit && (sel == SEL_DATA);

    assign unused_bits = ^{bus_wdata[DATA_W-1:IBRD_W], bus_wdata[3:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_hit) begin
            case (sel)
                SEL_IDIV: cfg.idiv    <= bus_wdata[IBRD_W-1:0];
                SEL_FDIV: cfg.fdiv    <= bus_wdata[FBRD_W-1:0];
                SEL_LINE: begin
                    cfg.wlen <= bus_wdata[LN_WLEN_LO +: 2];
                    cfg.q_en <= bus_wdata[LN_QUEUE_EN];
                end
                SEL_CTRL: cfg.port_en <= bus_wdata[CT_PORT_EN];
                default:  cfg         <= cfg;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            case (sel)
                SEL_DATA: bus_rdata = rx_empty ? '0 : DATA_W'(rx_head);
                SEL_FLAG: bus_rdata = pack_flags(rx_empty, tx_full);
                SEL_IDIV: bus_rdata = DATA_W'(cfg.idiv);
                SEL_FDIV: bus_rdata = DATA_W'(cfg.fdiv);
                SEL_LINE: bus_rdata = pack_line(cfg);
                SEL_CTRL: bus_rdata = DATA_W'(cfg.port_en);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R8: the integer divisor moves only on a write to its own offset
    a_r8_idiv_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && sel == SEL_IDIV) |=> $stable(cfg.idiv));

    // R9: the port enable moves only on a write to the control offset
    a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && sel == SEL_CTRL) |=> $stable(cfg.port_en));

endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
    import uart_regs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic [15:0]       baud_int,
    output logic [5:0]        baud_frac,
    output logic [1:0]        word_len
);
    cfg_t              cfg;
    logic              tx_push, tx_empty, tx_full;
    logic [BYTE_W-1:0] tx_push_data;
    logic              rx_pop, rx_empty, rx_full, rx_push;
    logic [BYTE_W-1:0] rx_head;
    logic              tx_take;

    uart_bus_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .rx_empty     (rx_empty),
        .tx_full      (tx_full),
        .rx_head      (rx_head),
        .tx_push      (tx_push),
        .tx_push_data (tx_push_data),
        .rx_pop       (rx_pop),
        .cfg          (cfg)
    );

    assign tx_valid = cfg.port_en && !tx_empty;
    assign tx_take  = tx_valid && tx_ready;

    uart_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .one_entry (!cfg.q_en),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_take),
        .head      (tx_data),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    assign rx_push = rx_valid && cfg.port_en;

    uart_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .one_entry (!cfg.q_en),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    assign baud_int  = cfg.idiv;
    assign baud_frac = cfg.fdiv;
    assign word_len  = cfg.wlen;

    // R2: an offered byte stays offered and unchanged until taken
    a_r2_tx_hold: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready && !(bus_sel && bus_wr && decode_addr(bus_addr) == SEL_CTRL)
        |=> tx_valid && $stable(tx_data));

    // R7: with the port disabled an empty receive queue stays empty
    a_r7_rx_discard: assert property (@(posedge clk) disable iff (rst)
        !cfg.port_en && rx_empty |=> rx_empty);

    // R6: single-slot mode never reports the receive queue as anything but full once occupied
    a_r6_rx_slot: assert property (@(posedge clk) disable iff (rst)
        !cfg.q_en && !rx_empty |-> rx_full);

endmodule

// File: tb/uart_reg_front_tb.sv
module uart_reg_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    localparam logic [11:0] A_DATA = 12'h000;
    localparam logic [11:0] A_FLAG = 12'h018;
    localparam logic [11:0] A_IDIV = 12'h024;
    localparam logic [11:0] A_FDIV = 12'h028;
    localparam logic [11:0] A_LINE = 12'h02C;
    localparam logic [11:0] A_CTRL = 12'h030;

    // {offset, write value, expected read-back}
    localparam logic [75:0] VEC [8] = '{
        {A_IDIV, 32'h0000_001B, 32'h0000_001B},
        {A_IDIV, 32'hABCD_1234, 32'h0000_1234},
        {A_FDIV, 32'h0000_0048, 32'h0000_0008},
        {A_FDIV, 32'hFFFF_FFFF, 32'h0000_003F},
        {A_LINE, 32'hFFFF_FFFF, 32'h0000_0070},
        {A_LINE, 32'h0000_0060, 32'h0000_0060},
        {A_CTRL, 32'h0000_00FF, 32'h0000_0001},
        {A_CTRL, 32'h0000_0000, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] baud_int;
    logic [5:0]  baud_frac;
    logic [1:0]  word_len;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_reg_front #(.DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .baud_int  (baud_int),
        .baud_frac (baud_frac),
        .word_len  (word_len)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(A_FLAG, rd); chk("R1 flags", rd, 32'h10);
        bus_read(A_IDIV, rd); chk("R1 idiv", rd, 32'h0);
        bus_read(A_LINE, rd); chk("R1 line", rd, 32'h0);
        bus_read(A_CTRL, rd); chk("R1 ctrl", rd, 32'h0);
        chk("R1 outputs", {tx_valid, baud_int, baud_frac, word_len}, 32'h0);

        // R8 R9 register table
        for (int i = 0; i < 8; i++) begin
            bus_write(VEC[i][75:64], VEC[i][63:32]);
            bus_read(VEC[i][75:64], rd);
            chk("R8/R9 readback", rd, VEC[i][31:0]);
        end
        chk("R8 baud_int", 32'(baud_int), 32'h1234);
        chk("R8 baud_frac", 32'(baud_frac), 32'h3F);

        // configure: 27 / 8, 8 bits, queues on, enabled
        bus_write(A_IDIV, 32'd27);
        bus_write(A_FDIV, 32'd8);
        bus_write(A_LINE, 32'h70);
        bus_write(A_CTRL, 32'h1);
        chk("R9 word_len", 32'(word_len), 32'h3);
        chk("R8 divisors", {baud_int, 10'b0, baud_frac}, {16'd27, 10'b0, 6'd8});

        // R2 handshake and order
        bus_write(A_DATA, 32'h1A5);
        chk("R2 valid", 32'(tx_valid), 32'h1);
        chk("R2 data", 32'(tx_data), 32'hA5);
        bus_write(A_DATA, 32'h3C);
        @(negedge clk); @(negedge clk);
        chk("R2 held", {tx_valid, tx_data}, {23'b0, 1'b1, 8'hA5});
        tx_ready = 1'b1;
        @(negedge clk);
        chk("R2 second", {tx_valid, tx_data}, {23'b0, 1'b1, 8'h3C});
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R2 drained", 32'(tx_valid), 32'h0);

        // R3 fill to full, overflow dropped
        for (int i = 0; i < DEPTH; i++) begin
            bus_write(A_DATA, 32'(i + 8'h40));
        end
        bus_read(A_FLAG, rd); chk("R3 full flag", rd & 32'h20, 32'h20);
        bus_write(A_DATA, 32'hEE);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 order", {tx_valid, tx_data}, {23'b0, 1'b1, 8'(i + 8'h40)});
            tx_ready = 1'b1;
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R3 overflow dropped", 32'(tx_valid), 32'h0);
        bus_read(A_FLAG, rd); chk("R3 not full", rd & 32'h20, 32'h0);

        // R4 receive order and empty flag
        rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
        bus_read(A_FLAG, rd); chk("R4 not empty", rd & 32'h10, 32'h0);
        bus_read(A_DATA, rd); chk("R4 byte0", rd, 32'h11);
        bus_read(A_DATA, rd); chk("R4 byte1", rd, 32'h22);
        bus_read(A_DATA, rd); chk("R4 byte2", rd, 32'h33);
        bus_read(A_FLAG, rd); chk("R4 empty", rd & 32'h10, 32'h10);

        // R5 empty read
        bus_read(A_DATA, rd); chk("R5 empty read", rd, 32'h0);
        rx_send(8'h44);
        bus_read(A_DATA, rd); chk("R5 pointers intact", rd, 32'h44);
        bus_read(A_FLAG, rd); chk("R5 empty after", rd & 32'h10, 32'h10);

        // R6 single-slot mode
        bus_write(A_LINE, 32'h60);
        bus_write(A_DATA, 32'h01);
        bus_read(A_FLAG, rd); chk("R6 tx full", rd & 32'h20, 32'h20);
        bus_write(A_DATA, 32'h02);
        chk("R6 head", {tx_valid, tx_data}, {23'b0, 1'b1, 8'h01});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R6 second dropped", 32'(tx_valid), 32'h0);
        rx_send(8'h55); rx_send(8'h66);
        bus_read(A_DATA, rd); chk("R6 rx kept", rd, 32'h55);
        bus_read(A_DATA, rd); chk("R6 rx dropped", rd, 32'h0);

        // R7 port disabled
        bus_write(A_CTRL, 32'h0);
        bus_write(A_DATA, 32'h77);
        chk("R7 tx quiet", 32'(tx_valid), 32'h0);
        rx_send(8'h88);
        bus_read(A_FLAG, rd); chk("R7 rx discarded", rd & 32'h10, 32'h10);
        bus_write(A_CTRL, 32'h1);
        chk("R7 tx resumes", {tx_valid, tx_data}, {23'b0, 1'b1, 8'h77});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R7 drained", 32'(tx_valid), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule